// File: doc/BRIEF.md
# Firmware Page Download Sequencer

This block loads a firmware image into a microcontroller's program memory through a paged download window and then carries out the completion handshake. After a `start` pulse it latches the image length, switches the control/status register model into download mode, and consumes the image as a byte stream. Each byte goes to a byte offset inside the currently selected page. The image is cut into whole pages followed, when the length is not a multiple of the page size, by one shorter page at the next index.

Once the last byte is written, the block leaves download mode and polls the checksum-report bit for a bounded number of cycles. If the report shows up, a read-modify-write of the control word sets the firmware-ready bit. If it does not, the run ends with an error and ready stays clear. An image with too many whole pages is refused before any byte is written. The register model is held inside the block and is visible on its outputs. Byte 1 of the control word belongs to a neighbouring controller and is written only through its own port.

Top module: `fw_page_loader`

## Requirements
- R1: Byte k of an image (counted from 0) is written with `page_sel` = k / PAGE_BYTES, `wr_addr` = k % PAGE_BYTES and `wr_data` equal to the k-th stream byte. Whole pages take indices 0 to n-1 and a non-zero remainder goes to index n. Exactly as many bytes are written as the latched length.
- R2: If the whole-page count (length / PAGE_BYTES) exceeds MAX_PAGES, no byte is written and no poll takes place. `err` is raised and `busy` lasts exactly 3 cycles.
- R3: Entering download mode does four things and leaves every other bit as it was: it sets bit 2 of `fen_byte`, sets `ctl_word` bit 0 (download enable), clears `ctl_word` bit 19 (bit 3 of byte 2) and clears `ctl_word` bit 1 (ready).
- R4: Leaving download mode clears only `ctl_word` bit 0, and does so before the poll starts. Bit 0 is 1 during every byte write and 0 when `done` pulses. `ctl_word[15:8]` changes only on a `peer_we` cycle, where it takes `peer_byte`.
- R5: `ctl_word` bit 2 is `chk_in` registered. The poll samples it at most POLL_LIMIT times. If it never reads 1, the run ends with `err` = 1 and `ctl_word` bit 1 = 0. For a zero-length image, `busy` then lasts POLL_LIMIT + 3 cycles.
- R6: When the poll reads the checksum bit as 1, `ctl_word` bit 1 (ready) is set and the run ends with `err` = 0.
- R7: A `start` pulse while `busy` is high has no effect on the running transfer or its length.
- R8: A zero-length image writes nothing and goes straight to the poll. With the checksum report already present, `busy` lasts exactly 4 cycles.
- R9: `done` is a one-cycle pulse with `busy` high. `busy` is low in the cycle that follows. `err` is valid from `done` until the next accepted start.
- R10: A stream byte is consumed only in a cycle where both `src_valid` and `src_ready` are high. `src_ready` is high only while bytes remain to be written. Gaps in `src_valid` only stretch the transfer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Begin a download (accepted only when idle) |
| img_len | input | LEN_W | Image length in bytes, latched at start |
| src_valid | input | 1 | Stream byte available |
| src_data | input | 8 | Stream byte |
| src_ready | output | 1 | Block accepts a stream byte |
| wr_en | output | 1 | Write strobe into the download window |
| page_sel | output | PG_W | Page index of the download window |
| wr_addr | output | OFS_W | Byte offset inside the page |
| wr_data | output | 8 | Byte written |
| chk_in | input | 1 | Checksum report from the microcontroller side |
| peer_we | input | 1 | Neighbour write strobe for control byte 1 |
| peer_byte | input | 8 | Neighbour value for control byte 1 |
| fen_byte | output | 8 | Function-enable byte of the register model |
| ctl_word | output | 32 | Download control/status word of the register model |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | Last run failed (page overflow or poll timeout) |

## Verification
On every cycle, the assertions check that writes only happen with download enabled and on a page index inside the allowed range. They also check that control byte 1 moves only on neighbour writes, that ready rises only after a checksum report was held, that the poll counter stays within its limit, that a completed run has download disabled, and that a failed run never shows ready. The address and data of each individual byte, the exact busy length of the short paths, the preserved bits of the function-enable and byte-2 fields, and the ignored mid-run start can be seen only by the bench. It sweeps every legal length of a small configuration with and without stream gaps, and drives timeout, late-report and overflow runs.

// File: rtl/fwl_pkg.sv
// Shared types for the firmware page loader.
// Assumes nothing beyond a single clock domain.
package fwl_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ENTER,
        ST_WRITE,
        ST_LEAVE,
        ST_POLL,
        ST_FIN
    } fwl_state_t;

    localparam int CTL_EN_BIT   = 0;
    localparam int CTL_RDY_BIT  = 1;
    localparam int CTL_CHK_BIT  = 2;
    localparam int CTL_B2B3_BIT = 19;
    localparam int FEN_CPU_BIT  = 2;
endpackage

// File: rtl/fwl_split.sv
// Splits an image length into whole pages and a remainder, and flags an
// oversized image. Assumes PAGE_BYTES is a power of two and LEN_W > OFS_W.
module fwl_split #(
    parameter int PAGE_BYTES = 4096,
    parameter int LEN_W      = 16,
    parameter int MAX_PAGES  = 8,
    localparam int OFS_W     = $clog2(PAGE_BYTES),
    localparam int PG_W      = $clog2(MAX_PAGES + 1)
) (
    input  logic [LEN_W-1:0] len,
    output logic [PG_W-1:0]  full_pages,
    output logic [OFS_W-1:0] rem_bytes,
    output logic [PG_W-1:0]  total_pages,
    output logic             too_many
);
    logic [LEN_W-1:0] full_w;

    // Page arithmetic: shift for the page count, low bits for the remainder.
    always_comb begin
        full_w      = len >> OFS_W;
        rem_bytes   = len[OFS_W-1:0];
        too_many    = full_w > LEN_W'(MAX_PAGES);
        full_pages  = full_w[PG_W-1:0];
        total_pages = full_w[PG_W-1:0] + PG_W'(rem_bytes != '0);
    end
endmodule

// File: rtl/fwl_writer.sv
// Walks the download window page by page, taking one stream byte per
// accepted cycle. Assumes full/rem/total stay stable while active and total>0.
module fwl_writer #(
    parameter int PAGE_BYTES = 4096,
    parameter int MAX_PAGES  = 8,
    localparam int OFS_W     = $clog2(PAGE_BYTES),
    localparam int PG_W      = $clog2(MAX_PAGES + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             go,
    input  logic [PG_W-1:0]  full_pages,
    input  logic [OFS_W-1:0] rem_bytes,
    input  logic [PG_W-1:0]  total_pages,
    input  logic             src_valid,
    input  logic [7:0]       src_data,
    output logic             src_ready,
    output logic             wr_en,
    output logic [PG_W-1:0]  page_sel,
    output logic [OFS_W-1:0] wr_addr,
    output logic [7:0]       wr_data,
    output logic             fin
);
    logic             active;
    logic [PG_W-1:0]  pg;
    logic [OFS_W-1:0] ofs;
    logic [OFS_W:0]   cur_len;
    logic             last_byte;

    // Length of the page being written: whole page or the remainder.
    always_comb begin
        cur_len   = (pg < full_pages) ? (OFS_W+1)'(PAGE_BYTES) : {1'b0, rem_bytes};
        last_byte = ({1'b0, ofs} == cur_len - 1'b1);
        src_ready = active;
        wr_en     = active && src_valid;
        page_sel  = pg;
        wr_addr   = ofs;
        wr_data   = src_data;
    end

    // Page and offset counters; page index advances right after a page's last byte.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active <= 1'b0;
            pg     <= '0;
            ofs    <= '0;
            fin    <= 1'b0;
        end else begin
            fin <= 1'b0;
            if (go) begin
                active <= 1'b1;
                pg     <= '0;
                ofs    <= '0;
            end else if (wr_en) begin
                if (last_byte) begin
                    ofs <= '0;
                    pg  <= pg + 1'b1;
                    if (pg + 1'b1 == total_pages) begin
                        active <= 1'b0;
                        fin    <= 1'b1;
                    end
                end else begin
                    ofs <= ofs + 1'b1;
                end
            end
        end
    end

    // R1
    wr_page_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> (page_sel < total_pages));
    // R1
    wr_ofs_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> ({1'b0, wr_addr} < cur_len));
endmodule

// File: rtl/fwl_ctlreg.sv
// Register model: function-enable byte and the 32-bit download control word.
// Byte 1 of the control word belongs to a neighbour and changes only on its strobe.
module fwl_ctlreg #(
    parameter logic [7:0]  FEN_RST = 8'h00,
    parameter logic [31:0] CTL_RST = 32'h00FF_0000
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        do_enter,
    input  logic        do_leave,
    input  logic        do_ready,
    input  logic        chk_in,
    input  logic        peer_we,
    input  logic [7:0]  peer_byte,
    output logic [7:0]  fen_byte,
    output logic [31:0] ctl_word
);
    import fwl_pkg::*;

    // Read-modify-write updates of the register model.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fen_byte <= FEN_RST;
            ctl_word <= CTL_RST;
        end else begin
            ctl_word[CTL_CHK_BIT] <= chk_in;
            if (peer_we)
                ctl_word[15:8] <= peer_byte;
            if (do_enter) begin
                fen_byte[FEN_CPU_BIT]  <= 1'b1;
                ctl_word[CTL_EN_BIT]   <= 1'b1;
                ctl_word[CTL_RDY_BIT]  <= 1'b0;
                ctl_word[CTL_B2B3_BIT] <= 1'b0;
            end
            if (do_leave)
                ctl_word[CTL_EN_BIT] <= 1'b0;
            if (do_ready)
                ctl_word[CTL_RDY_BIT] <= 1'b1;
        end
    end

    // R4
    peer_byte_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !peer_we |=> $stable(ctl_word[15:8]));
    // R6
    ready_after_report_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ctl_word[CTL_RDY_BIT]) |-> $past(ctl_word[CTL_CHK_BIT]));
    // R3
    enable_with_cpu_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ctl_word[CTL_EN_BIT]) |-> fen_byte[FEN_CPU_BIT]);
endmodule

// File: rtl/fw_page_loader.sv
// Firmware page download sequencer: enter download mode, write the image
// page by page, leave download mode, poll the checksum report, set ready.
// Assumes PAGE_BYTES is a power of two and POLL_LIMIT >= 1.
module fw_page_loader #(
    parameter int          PAGE_BYTES = 4096,
    parameter int          LEN_W      = 16,
    parameter int          MAX_PAGES  = 8,
    parameter int          POLL_LIMIT = 1000,
    parameter logic [7:0]  FEN_RST    = 8'h00,
    parameter logic [31:0] CTL_RST    = 32'h00FF_0000,
    localparam int         OFS_W      = $clog2(PAGE_BYTES),
    localparam int         PG_W       = $clog2(MAX_PAGES + 1),
    localparam int         PC_W       = $clog2(POLL_LIMIT + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [LEN_W-1:0] img_len,
    input  logic             src_valid,
    input  logic [7:0]       src_data,
    output logic             src_ready,
    output logic             wr_en,
    output logic [PG_W-1:0]  page_sel,
    output logic [OFS_W-1:0] wr_addr,
    output logic [7:0]       wr_data,
    input  logic             chk_in,
    input  logic             peer_we,
    input  logic [7:0]       peer_byte,
    output logic [7:0]       fen_byte,
    output logic [31:0]      ctl_word,
    output logic             busy,
    output logic             done,
    output logic             err
);
    import fwl_pkg::*;

    fwl_state_t       state;
    logic [LEN_W-1:0] len_q;
    logic [PC_W-1:0]  poll_cnt;
    logic             err_q;
    logic [PG_W-1:0]  full_pages;
    logic [OFS_W-1:0] rem_bytes;
    logic [PG_W-1:0]  total_pages;
    logic             too_many;
    logic             go;
    logic             fin;
    logic             do_enter;
    logic             do_leave;
    logic             do_ready;

    fwl_split #(
        .PAGE_BYTES(PAGE_BYTES), .LEN_W(LEN_W), .MAX_PAGES(MAX_PAGES)
    ) u_split (
        .len(len_q), .full_pages(full_pages), .rem_bytes(rem_bytes),
        .total_pages(total_pages), .too_many(too_many)
    );

    fwl_writer #(
        .PAGE_BYTES(PAGE_BYTES), .MAX_PAGES(MAX_PAGES)
    ) u_writer (
        .clk(clk), .rst_n(rst_n), .go(go),
        .full_pages(full_pages), .rem_bytes(rem_bytes), .total_pages(total_pages),
        .src_valid(src_valid), .src_data(src_data), .src_ready(src_ready),
        .wr_en(wr_en), .page_sel(page_sel), .wr_addr(wr_addr), .wr_data(wr_data),
        .fin(fin)
    );

    fwl_ctlreg #(
        .FEN_RST(FEN_RST), .CTL_RST(CTL_RST)
    ) u_regs (
        .clk(clk), .rst_n(rst_n), .do_enter(do_enter), .do_leave(do_leave),
        .do_ready(do_ready), .chk_in(chk_in), .peer_we(peer_we),
        .peer_byte(peer_byte), .fen_byte(fen_byte), .ctl_word(ctl_word)
    );

    // State-derived strobes toward the writer and the register model.
    always_comb begin
        do_enter = (state == ST_ENTER);
        do_leave = (state == ST_LEAVE);
        do_ready = (state == ST_POLL) && ctl_word[CTL_CHK_BIT];
        go       = do_enter && !too_many && (total_pages != '0);
        busy     = (state != ST_IDLE);
        done     = (state == ST_FIN);
        err      = err_q;
    end

    // Sequence control: entry, page writes, exit, bounded checksum poll.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= ST_IDLE;
            len_q    <= '0;
            poll_cnt <= '0;
            err_q    <= 1'b0;
        end else begin
            case (state)
                ST_IDLE: if (start) begin
                    len_q <= img_len;
                    err_q <= 1'b0;
                    state <= ST_ENTER;
                end
                ST_ENTER: begin
                    if (too_many) begin
                        err_q <= 1'b1;
                        state <= ST_LEAVE;
                    end else if (total_pages == '0) begin
                        state <= ST_LEAVE;
                    end else begin
                        state <= ST_WRITE;
                    end
                end
                ST_WRITE: if (fin) state <= ST_LEAVE;
                ST_LEAVE: begin
                    poll_cnt <= '0;
                    state    <= err_q ? ST_FIN : ST_POLL;
                end
                ST_POLL: begin
                    if (ctl_word[CTL_CHK_BIT]) begin
                        state <= ST_FIN;
                    end else if (poll_cnt == PC_W'(POLL_LIMIT - 1)) begin
                        err_q <= 1'b1;
                        state <= ST_FIN;
                    end else begin
                        poll_cnt <= poll_cnt + 1'b1;
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    // R4
    write_needs_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> ctl_word[CTL_EN_BIT]);
    // R4
    finish_disabled_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !ctl_word[CTL_EN_BIT]);
    // R5
    fail_not_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done && err) |-> !ctl_word[CTL_RDY_BIT]);
    // R5
    poll_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        poll_cnt < PC_W'(POLL_LIMIT));
    // R7
    start_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && start) |=> $stable(len_q));
    // R1
    page_in_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> (page_sel <= PG_W'(MAX_PAGES)));
endmodule

// File: tb/fw_page_loader_test.sv
// Sweep bench over a small configuration: 16-byte pages, up to 8 whole pages.
module fw_page_loader_test;
    localparam int PB = 16;
    localparam int LW = 8;
    localparam int MP = 8;
    localparam int PL = 12;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       start = 1'b0;
    logic [7:0] img_len = '0;
    logic       src_valid = 1'b0;
    logic [7:0] src_data = '0;
    logic       src_ready;
    logic       wr_en;
    logic [3:0] page_sel;
    logic [3:0] wr_addr;
    logic [7:0] wr_data;
    logic       chk_in = 1'b0;
    logic       peer_we = 1'b0;
    logic [7:0] peer_byte = '0;
    logic [7:0] fen_byte;
    logic [31:0] ctl_word;
    logic       busy, done, err;

    int n_cmp = 0;
    int n_bad = 0;
    int cyc = 0;
    logic [7:0] peer_exp = 8'h00;

    fw_page_loader #(
        .PAGE_BYTES(PB), .LEN_W(LW), .MAX_PAGES(MP), .POLL_LIMIT(PL),
        .FEN_RST(8'h41), .CTL_RST(32'h00FF_0000)
    ) uut (
        .clk(clk), .rst_n(rst_n), .start(start), .img_len(img_len),
        .src_valid(src_valid), .src_data(src_data), .src_ready(src_ready),
        .wr_en(wr_en), .page_sel(page_sel), .wr_addr(wr_addr), .wr_data(wr_data),
        .chk_in(chk_in), .peer_we(peer_we), .peer_byte(peer_byte),
        .fen_byte(fen_byte), .ctl_word(ctl_word),
        .busy(busy), .done(done), .err(err)
    );

    always #2 clk = ~clk;

    task automatic summary_and_end();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    // Watchdog: a hung run counts as a failed check.
    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 150000) begin
            n_cmp++; n_bad++;
            $display("FAIL watchdog: cycles %0d expected below 150000", cyc);
            summary_and_end();
        end
    end

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    function automatic logic [7:0] pat(input int idx, input int len);
        return 8'((idx * 7 + len) & 255);
    endfunction

    // mode 0: report present; 1: never; 2: raised a few cycles after the last write
    task automatic run(input int len, input int mode, input bit gap, input bit stray);
        int  nwr = 0;
        int  bcnt = 0;
        int  it = 0;
        int  wait_cnt = 0;
        bit  ovf = ((len / PB) > MP);
        bit  exp_err;
        bit  fin_seen = 0;
        chk_in = (mode == 0);
        @(negedge clk);
        start = 1'b1; img_len = 8'(len);
        @(negedge clk);
        start = 1'b0;
        while (!fin_seen) begin
            if (stray && it == 1) begin
                start = 1'b1; img_len = 8'(len + 5);
                peer_we = 1'b1; peer_byte = 8'(len ^ 8'h3C); peer_exp = 8'(len ^ 8'h3C);
            end else if (stray && it == 2) begin
                start = 1'b0; peer_we = 1'b0;
            end
            if (mode == 2 && nwr == len) begin
                wait_cnt++;
                if (wait_cnt == 4) chk_in = 1'b1;
            end
            src_valid = gap ? ((it % 3) != 2) : 1'b1;
            src_data  = pat(nwr, len);
            #1;
            if (busy) bcnt++;
            if (wr_en) begin
                // R1 R10
                check(page_sel == 4'(nwr / PB), "R1", "page index", page_sel, nwr / PB);
                check(wr_addr == 4'(nwr % PB), "R1", "byte offset", wr_addr, nwr % PB);
                check(wr_data == pat(nwr, len), "R1", "data", wr_data, pat(nwr, len));
                check(src_ready && src_valid, "R10", "handshake", src_ready, 1);
                check(ctl_word[0] == 1'b1, "R4", "enable during write", ctl_word[0], 1);
                nwr++;
            end
            if (done) fin_seen = 1;
            it++;
            if (it > 1000) begin
                check(0, "R9", "run end", 0, 1);
                break;
            end
            if (!fin_seen) @(negedge clk);
        end
        start = 1'b0; peer_we = 1'b0;
        exp_err = ovf || (mode == 1);
        check(nwr == (ovf ? 0 : len), ovf ? "R2" : "R1", "bytes written", nwr, ovf ? 0 : len);
        check(err == exp_err, exp_err ? (ovf ? "R2" : "R5") : "R6", "err", err, exp_err);
        check(ctl_word[1] == !exp_err, exp_err ? "R5" : "R6", "ready bit", ctl_word[1], !exp_err);
        check(ctl_word[0] == 1'b0, "R4", "enable cleared", ctl_word[0], 0);
        check(ctl_word[15:8] == peer_exp, "R4", "peer byte", ctl_word[15:8], peer_exp);
        check(fen_byte == 8'h45, "R3", "function enable", fen_byte, 8'h45);
        check(ctl_word[23:16] == 8'hF7, "R3", "byte 2", ctl_word[23:16], 8'hF7);
        if (ovf)
            check(bcnt == 3, "R2", "busy cycles", bcnt, 3);
        if (len == 0 && mode == 0)
            check(bcnt == 4, "R8", "busy cycles", bcnt, 4);
        if (len == 0 && mode == 1)
            check(bcnt == PL + 3, "R5", "busy cycles", bcnt, PL + 3);
        @(negedge clk);
        #1;
        // R9
        check(!busy && !done, "R9", "idle after done", {busy, done}, 0);
        check(err == exp_err, "R9", "err held", err, exp_err);
        check(!src_ready, "R10", "ready idle", src_ready, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        #1;
        check(!busy && !done && !err && !wr_en, "R9", "reset outputs", {busy, done, err, wr_en}, 0);
        check(ctl_word == 32'h00FF_0000, "R3", "reset control word", ctl_word, 32'h00FF_0000);
        check(fen_byte == 8'h41, "R3", "reset function enable", fen_byte, 8'h41);
        rst_n = 1'b1;
        @(negedge clk);
        // R8: zero-length, report present
        run(0, 0, 0, 0);
        // R5: zero-length timeout, exact poll length
        run(0, 1, 0, 0);
        // R7: stray start and neighbour write during a run
        run(37, 0, 0, 1);
        run(0, 0, 0, 1);
        // R2: overflow lengths
        run(144, 0, 0, 0);
        run(200, 0, 1, 1);
        run(255, 1, 0, 0);
        // R1 R10: every legal length, alternating gaps and report timing
        for (int len = 1; len <= MP * PB + PB - 1; len++) begin
            if (len % 5 == 0) begin
                @(negedge clk);
                peer_we = 1'b1; peer_byte = 8'(len ^ 8'h5A); peer_exp = 8'(len ^ 8'h5A);
                @(negedge clk);
                peer_we = 1'b0;
            end
            run(len, (len % 4 == 3) ? 1 : ((len % 4 == 1) ? 2 : 0), len[0], 0);
        end
        summary_and_end();
    end
endmodule